// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Sequencer

This block holds the 21-bit byte program counter of a core with 16-bit instructions. It overlaps the fetch of one word with the execution of the word before it. Each cycle it puts a fetch address on the program-memory port and reads the returned word in the same cycle. On the next clock edge the word moves into the execute slot, where the rest of the core sees it together with its address and a valid flag.

The sequencer decodes only the words that change flow. These are the long unconditional relative branch, the short conditional relative branch (its condition comes from the core on `cond_met`), and the two-word absolute jump and call. For a two-word instruction, the second word is read from the fetch port while the first word executes. The block also steers fetch to the reset vector and to two fixed interrupt vectors. Every redirect turns the word already prefetched into a bubble. Program addresses at or above the implemented size read as zero.

Top module: `fetch_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows fetch address 0x000000 and `exec_valid` low. Fetch starts from 0x000000 when reset is released.
- R2: With no flow change and no interrupt, the fetch address grows by 2 each cycle. The word returned for fetch address A is in the execute slot one cycle later.
- R3: A word with bits [15:11] = 11010 is a long branch with a signed 11-bit word offset in bits [10:0]. The next fetch address is exec address + 2 + 2×offset, modulo 2^21. `exec_valid` is low in the cycle that follows.
- R4: A word with bits [15:11] = 11100 is a conditional branch with a signed 8-bit word offset in bits [7:0]. If `cond_met` is high in its execute cycle, it redirects like R3. If not, fetch continues at +2 with no bubble.
- R5: A word with bits [15:8] = 0xEF (jump) or 0xEC/0xED (call) is the first of two words. The target byte address is {second word [11:0], first word [7:0], 0}. The second word is read at the fetch port while the first word executes and is then discarded, so `exec_valid` is low for one cycle.
- R6: A word with bits [15:12] = 1111 that reaches the execute slot by itself is shown with `exec_valid` low, which makes it a no-operation.
- R7: `irq_hi` sends the next fetch to 0x000008 and `irq_lo` sends it to 0x000018. When both are high, `irq_hi` wins. The prefetched word is flushed.
- R8: A redirecting instruction in the execute slot (R3, a taken R4, R5) wins over an interrupt request in the same cycle. That request is ignored.
- R9: A word fetched from a byte address ≥ `IMPL_BYTES` enters the execute slot as 0x0000.
- R10: `exec_addr` always equals the fetch address of the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_hi | input | 1 | High-priority interrupt request |
| irq_lo | input | 1 | Low-priority interrupt request |
| cond_met | input | 1 | Condition result for the conditional branch in the execute slot |
| imem_rdata | input | 16 | Word read at `imem_addr` in the same cycle |
| imem_addr | output | 21 | Program byte fetch address |
| exec_word | output | 16 | Word in the execute slot |
| exec_valid | output | 1 | Execute-slot word is a real instruction |
| exec_addr | output | 21 | Byte address of the execute-slot word |

## Verification
On every cycle, the assertions check the reset vector, the +2 step after a plain word, the bubble after a long branch or a two-word jump, the vector address after an accepted interrupt, the fall-through of an untaken conditional branch, zero words from the unimplemented region and the one-cycle address lag of the execute slot. Other behaviours show up only in the bench scenarios. These are the exact target values for negative offsets, the assembly of a two-word target from a live second word, an orphan second word, and the timed collisions between an interrupt and a taken branch. The bench's reference model follows each of these step by step.

// File: rtl/fetch_seq_pkg.sv
// Shared types and constants for the fetch sequencer.
// Assumes 16-bit instruction words and byte program addresses.
package fetch_seq_pkg;
    localparam int unsigned INSTR_W     = 16;
    localparam int unsigned VEC_HI_BYTE = 8;
    localparam int unsigned VEC_LO_BYTE = 24;

    // Flow class of a word sitting in the execute slot.
    typedef enum logic [2:0] {
        K_PLAIN,
        K_REL_LONG,
        K_REL_COND,
        K_FAR,
        K_TAIL
    } ctl_kind_e;
endpackage

// File: rtl/fseq_decode.sv
// Classifies an instruction by its top byte into the flow classes the
// sequencer acts on. Assumes nothing about non-control opcodes.
module fseq_decode
    import fetch_seq_pkg::*;
(
    input  logic [7:0] op,
    output ctl_kind_e  kind
);
    // Pick the flow class; second-word marker is checked first.
    always_comb begin
        if (op[7:4] == 4'hF)
            kind = K_TAIL;
        else if (op == 8'hEF || op[7:1] == 7'b1110110)
            kind = K_FAR;
        else if (op[7:3] == 5'b11010)
            kind = K_REL_LONG;
        else if (op[7:3] == 5'b11100)
            kind = K_REL_COND;
        else
            kind = K_PLAIN;
    end
endmodule

// File: rtl/fseq_target.sv
// Computes the redirect byte address for the execute-slot word.
// Relative offsets are signed word counts from the following word;
// far targets are word addresses built from both words.
module fseq_target
    import fetch_seq_pkg::*;
#(
    parameter int unsigned PC_W = 21
) (
    input  logic [PC_W-1:0] ex_addr,
    input  logic [10:0]     head,
    input  logic [11:0]     tail_lo,
    input  ctl_kind_e       kind,
    output logic [PC_W-1:0] target
);
    localparam int unsigned EXT_LONG = PC_W - 12;
    localparam int unsigned EXT_COND = PC_W - 9;

    logic [PC_W-1:0] link;
    logic [PC_W-1:0] rel_long;
    logic [PC_W-1:0] rel_cond;
    logic [PC_W-1:0] far_abs;

    assign link     = ex_addr + PC_W'(2);
    assign rel_long = {{EXT_LONG{head[10]}}, head[10:0], 1'b0};
    assign rel_cond = {{EXT_COND{head[7]}}, head[7:0], 1'b0};
    assign far_abs  = PC_W'({tail_lo, head[7:0], 1'b0});

    // Select the target that matches the flow class.
    always_comb begin
        unique case (kind)
            K_REL_LONG: target = link + rel_long;
            K_REL_COND: target = link + rel_cond;
            K_FAR:      target = far_abs;
            default:    target = link;
        endcase
    end
endmodule

// File: rtl/fseq_next.sv
// Next-fetch-address priority: a redirect from execute, then the
// high vector, then the low vector, then sequential. Also flags a flush.
module fseq_next
    import fetch_seq_pkg::*;
#(
    parameter int unsigned PC_W = 21
) (
    input  logic            ir_valid,
    input  ctl_kind_e       kind,
    input  logic            cond_met,
    input  logic            irq_hi,
    input  logic            irq_lo,
    input  logic [PC_W-1:0] seq_pc,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] next_pc,
    output logic            flush
);
    logic redirect;
    logic take_hi;
    logic take_lo;

    // Decide whether execute changes flow this cycle.
    always_comb begin
        redirect = 1'b0;
        if (ir_valid) begin
            unique case (kind)
                K_REL_LONG, K_FAR: redirect = 1'b1;
                K_REL_COND:        redirect = cond_met;
                default:           redirect = 1'b0;
            endcase
        end
    end

    assign take_hi = !redirect && irq_hi;
    assign take_lo = !redirect && !irq_hi && irq_lo;
    assign flush   = redirect || take_hi || take_lo;

    // Choose the next fetch address by priority.
    always_comb begin
        if (redirect)
            next_pc = target;
        else if (take_hi)
            next_pc = PC_W'(VEC_HI_BYTE);
        else if (take_lo)
            next_pc = PC_W'(VEC_LO_BYTE);
        else
            next_pc = seq_pc;
    end
endmodule

// File: rtl/fetch_seq.sv
// Two-stage fetch sequencer: owns the program counter, the execute-slot
// word and its address. Assumes a same-cycle program-memory read and an
// external condition evaluation for the conditional branch.
module fetch_seq
    import fetch_seq_pkg::*;
#(
    parameter int unsigned PC_W       = 21,
    parameter int unsigned IMPL_BYTES = 131072
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_hi,
    input  logic                irq_lo,
    input  logic                cond_met,
    input  logic [INSTR_W-1:0]  imem_rdata,
    output logic [PC_W-1:0]     imem_addr,
    output logic [INSTR_W-1:0]  exec_word,
    output logic                exec_valid,
    output logic [PC_W-1:0]     exec_addr
);
    localparam bit FULL_SPACE = longint'(IMPL_BYTES) >= (longint'(1) << PC_W);

    logic [PC_W-1:0]    pc_q;
    logic [PC_W-1:0]    ex_addr_q;
    logic [INSTR_W-1:0] ir_q;
    logic               ir_v_q;
    logic [INSTR_W-1:0] fetched;
    logic [PC_W-1:0]    target;
    logic [PC_W-1:0]    next_pc;
    logic               flush;
    ctl_kind_e          kind;

    // Zero words from the unimplemented part of the space, if any.
    generate
        if (FULL_SPACE) begin : g_full
            assign fetched = imem_rdata;
        end else begin : g_part
            assign fetched = (longint'(pc_q) >= longint'(IMPL_BYTES)) ? '0 : imem_rdata;
        end
    endgenerate

    fseq_decode u_dec (
        .op   (ir_q[15:8]),
        .kind (kind)
    );

    fseq_target #(.PC_W(PC_W)) u_tgt (
        .ex_addr (ex_addr_q),
        .head    (ir_q[10:0]),
        .tail_lo (fetched[11:0]),
        .kind    (kind),
        .target  (target)
    );

    fseq_next #(.PC_W(PC_W)) u_nxt (
        .ir_valid (ir_v_q),
        .kind     (kind),
        .cond_met (cond_met),
        .irq_hi   (irq_hi),
        .irq_lo   (irq_lo),
        .seq_pc   (pc_q + PC_W'(2)),
        .target   (target),
        .next_pc  (next_pc),
        .flush    (flush)
    );

    // Advance fetch and move the fetched word into the execute slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            ex_addr_q <= '0;
            ir_q      <= '0;
            ir_v_q    <= 1'b0;
        end else begin
            pc_q      <= next_pc;
            ex_addr_q <= pc_q;
            ir_q      <= fetched;
            ir_v_q    <= !flush;
        end
    end

    assign imem_addr  = pc_q;
    assign exec_word  = ir_q;
    assign exec_addr  = ex_addr_q;
    assign exec_valid = ir_v_q && (kind != K_TAIL);
endmodule

// File: rtl/fetch_seq_chk.sv
// Port-level properties of the fetch sequencer, bound into every instance.
// Assumes the same encodings as the block's requirements.
module fetch_seq_chk #(
    parameter int unsigned PC_W       = 21,
    parameter int unsigned IMPL_BYTES = 131072
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_hi,
    input logic            irq_lo,
    input logic            cond_met,
    input logic [PC_W-1:0] imem_addr,
    input logic [15:0]     exec_word,
    input logic            exec_valid,
    input logic [PC_W-1:0] exec_addr
);
    function automatic logic changes_flow(input logic [15:0] w, input logic c);
        return (w[15:11] == 5'b11010) || (w[15:8] == 8'hEF) ||
               (w[15:9] == 7'b1110110) || ((w[15:11] == 5'b11100) && c);
    endfunction

    function automatic logic is_plain(input logic [15:0] w);
        return (w[15:13] != 3'b111) && (w[15:11] != 5'b11010);
    endfunction

    logic ex_redirect;
    assign ex_redirect = exec_valid && changes_flow(exec_word, cond_met);

    assert_reset_vec_R1: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == '0 && !exec_valid));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && is_plain(exec_word) && !irq_hi && !irq_lo)
        |=> imem_addr == $past(imem_addr) + PC_W'(2));

    assert_long_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_word[15:11] == 5'b11010) |=> !exec_valid);

    assert_cond_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_word[15:11] == 5'b11100 && !cond_met && !irq_hi && !irq_lo)
        |=> imem_addr == $past(imem_addr) + PC_W'(2));

    assert_far_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && (exec_word[15:8] == 8'hEF || exec_word[15:9] == 7'b1110110))
        |=> !exec_valid);

    assert_hi_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && !ex_redirect) |=> (imem_addr == PC_W'(8) && !exec_valid));

    assert_lo_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && !irq_hi && !ex_redirect) |=> (imem_addr == PC_W'(24) && !exec_valid));

    assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(exec_addr) >= longint'(IMPL_BYTES)) |-> exec_word == 16'h0000);

    assert_exec_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> exec_addr == $past(imem_addr));
endmodule

bind fetch_seq fetch_seq_chk #(.PC_W(PC_W), .IMPL_BYTES(IMPL_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_hi     (irq_hi),
    .irq_lo     (irq_lo),
    .cond_met   (cond_met),
    .imem_addr  (imem_addr),
    .exec_word  (exec_word),
    .exec_valid (exec_valid),
    .exec_addr  (exec_addr)
);

// File: tb/fetch_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_seq_tb_top;
    localparam int IMPL = 512;
    localparam int MASK = (1 << 21) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_hi = 1'b0;
    logic        irq_lo = 1'b0;
    logic        cond_met = 1'b0;
    logic [15:0] imem_rdata;
    logic [20:0] imem_addr;
    logic [15:0] exec_word;
    logic        exec_valid;
    logic [20:0] exec_addr;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit live = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fetch_seq #(.PC_W(21), .IMPL_BYTES(IMPL)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_hi     (irq_hi),
        .irq_lo     (irq_lo),
        .cond_met   (cond_met),
        .imem_rdata (imem_rdata),
        .imem_addr  (imem_addr),
        .exec_word  (exec_word),
        .exec_valid (exec_valid),
        .exec_addr  (exec_addr)
    );

    // Program image: control words at chosen spots, plain filler elsewhere.
    function automatic int mem_at(input int a);
        case (a)
            'h02: return 'hD005;  // long branch +5 -> 0x0E
            'h0E: return 'hE003;  // conditional +3 -> 0x16
            'h10: return 'hEF20;  // jump, low byte 0x20
            'h12: return 'hF000;  // second word -> byte 0x40
            'h20: return 'hD7F0;  // long branch -16 -> 0x02
            'h40: return 'h1111;
            'h42: return 'hF123;  // orphan second word
            'h44: return 'hE0FD;  // conditional -3 -> 0x40
            'h46: return 'hEC00;  // call, low byte 0x00
            'h48: return 'hF004;  // second word -> byte 0x800
            default: return (a >= 1024) ? 'hA55A : ((a >> 1) & 'hFF);
        endcase
    endfunction

    assign imem_rdata = 16'(mem_at(int'(imem_addr)));

    // 0 plain, 1 long branch, 2 conditional, 3 two-word, 4 second word
    function automatic int kind_of(input int w);
        if ((w >> 12) == 'hF) return 4;
        if ((w >> 8) == 'hEF || (w >> 9) == 'h76) return 3;
        if ((w >> 11) == 'h1A) return 1;
        if ((w >> 11) == 'h1C) return 2;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference model state: expected fetch address, slot word, flags.
    int    m_pc = 0;
    int    m_ir = 0;
    int    m_ea = 0;
    bit    m_iv = 0;
    string why = "R1";

    always @(posedge clk) begin
        int fw;
        int k;
        int tgt;
        int off;
        bit redir;
        bit th;
        bit tl;
        fw = (m_pc >= IMPL) ? 0 : mem_at(m_pc);
        if (!rst_n) begin
            m_pc = 0; m_ir = 0; m_iv = 0; m_ea = 0; why = "R1";
        end else begin
            k = m_iv ? kind_of(m_ir) : 0;
            redir = 0;
            tgt = 0;
            why = (m_pc >= IMPL) ? "R9" : "R2";
            if (m_iv && kind_of(m_ir) == 4) why = "R6";
            case (k)
                1: begin
                    off = m_ir & 'h7FF;
                    if (off >= 1024) off -= 2048;
                    tgt = m_ea + 2 + 2 * off; redir = 1; why = "R3";
                end
                2: begin
                    if (cond_met) begin
                        off = m_ir & 'hFF;
                        if (off >= 128) off -= 256;
                        tgt = m_ea + 2 + 2 * off; redir = 1;
                    end
                    why = "R4";
                end
                3: begin
                    tgt = ((fw & 'hFFF) << 9) | ((m_ir & 'hFF) << 1);
                    redir = 1; why = "R5";
                end
                default: ;
            endcase
            th = !redir && irq_hi;
            tl = !redir && !irq_hi && irq_lo;
            if (th || tl) why = "R7";
            if (redir && (irq_hi || irq_lo)) why = "R8";
            m_ea = m_pc;
            m_ir = fw;
            m_iv = !(redir || th || tl);
            m_pc = redir ? (tgt & MASK) : th ? 8 : tl ? 24 : ((m_pc + 2) & MASK);
        end
        live = 1;
    end

    // Compare every cycle against the model, away from the clock edge.
    always @(negedge clk) begin
        if (live && !done) begin
            check(int'(imem_addr) == m_pc, why, "fetch address", int'(imem_addr), m_pc);
            check(exec_valid == (m_iv && kind_of(m_ir) != 4), why, "exec_valid",
                  int'(exec_valid), int'(m_iv && kind_of(m_ir) != 4));
            check(int'(exec_word) == m_ir, why, "exec_word", int'(exec_word), m_ir);
            check(int'(exec_addr) == m_ea, "R10", "exec_addr", int'(exec_addr), m_ea);
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic wait_exec(input int w);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(exec_valid && int'(exec_word) == w) && n < 2000);
        check(n < 2000, "R2", "reached word", int'(exec_word), w);
    endtask

    task automatic wait_addr(input int a);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (int'(exec_addr) != a && n < 2000);
        check(n < 2000, "R2", "reached address", int'(exec_addr), a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(imem_addr == 21'h0 && !exec_valid, "R1", "reset state",
              int'(imem_addr), 0);
        rst_n = 1'b1;

        wait_exec('hD005);
        @(negedge clk);
        check(imem_addr == 21'h0E && !exec_valid, "R3", "long branch target",
              int'(imem_addr), 'h0E);

        wait_exec('hEF20);
        @(negedge clk);
        check(imem_addr == 21'h40 && !exec_valid, "R5", "two-word target",
              int'(imem_addr), 'h40);

        wait_addr('h42);
        check(!exec_valid, "R6", "orphan second word", int'(exec_valid), 0);

        wait_exec('hEC00);
        repeat (4) @(negedge clk);
        check(exec_word == 16'h0 && int'(exec_addr) >= IMPL, "R9",
              "unimplemented word", int'(exec_word), 0);

        irq_hi = 1'b1; irq_lo = 1'b1;
        @(negedge clk);
        irq_hi = 1'b0; irq_lo = 1'b0;
        check(imem_addr == 21'h08 && !exec_valid, "R7", "high vector wins",
              int'(imem_addr), 'h08);

        wait_exec('hE003);
        cond_met = 1'b1;
        @(negedge clk);
        cond_met = 1'b0;
        check(imem_addr == 21'h16 && !exec_valid, "R4", "taken conditional",
              int'(imem_addr), 'h16);

        wait_exec('hD005);
        irq_hi = 1'b1;
        @(negedge clk);
        irq_hi = 1'b0;
        check(imem_addr == 21'h0E, "R8", "branch beats high request",
              int'(imem_addr), 'h0E);

        wait_exec('hE0FD);
        cond_met = 1'b1; irq_lo = 1'b1;
        @(negedge clk);
        cond_met = 1'b0; irq_lo = 1'b0;
        check(imem_addr == 21'h40, "R8", "taken conditional beats low request",
              int'(imem_addr), 'h40);

        wait_exec('hEC00);
        repeat (3) @(negedge clk);
        irq_lo = 1'b1;
        @(negedge clk);
        irq_lo = 1'b0;
        check(imem_addr == 21'h18 && !exec_valid, "R7", "low vector",
              int'(imem_addr), 'h18);

        repeat (6) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule